// File: doc/BRIEF.md
# SD Command Line Engine

This block issues one command on the single-wire command line of an SD or SDIO card and, when asked, receives the card's reply. It has no bus of its own. The surrounding controller presents a command index, a 32-bit argument, a reply length and a few per-command flags, then pulses a start strobe. The engine builds the 48-bit command frame with its CRC7 and shifts it out. It then either finishes at once or waits for the card's start bit. It captures the reply, checks the reply CRC7 if the command calls for that, and can hold off completion while the card keeps DAT0 low for busy.

The card clock comes from the system clock. A source clock at half the system rate is divided by a programmable value plus one. Commands change on the falling card-clock edge and replies are sampled on the rising edge. Completion is reported on a sticky done line, which the controller clears by a write-one strobe. A soft reset strobe abandons any command and returns the engine to idle.

Top module: `sd_cmd_engine`

## Requirements
- R1: The frame is 48 bits, most significant first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, then a CRC7 (generator x^7+x^3+1, zero preset) over those 40 bits, then a 1 end bit.
- R2: `cmd_out` changes only as `card_clk` falls. `cmd_oe` is high only for the 48 frame bits and drops on the falling edge after the last one. Out of reset the line is released (`cmd_oe` 0, `cmd_out` 1).
- R3: With divider value N, `card_clk` has a period of 2*(N+1) system clocks, and N = 0 gives half the system rate.
- R4: When a reply is expected, the first 0 sampled on a rising edge is the start bit. The next `resp_len`+1 bits (the end bit excluded) are shifted into `resp_data` from bit 0 upward, the most recent bit at bit 0 and the upper bits cleared. The value 45 captures a 48-bit reply.
- R5: For a short reply, `crc_ok` is 1 when the CRC7 of the captured bits, counted from the first bit after the start bit and with a 0 start bit in front, matches the last 7 captured bits.
- R6: With `resp_long` set, the first 7 captured bits (direction and reserved field) are left out of the CRC7 check. The value 133 captures a 136-bit reply.
- R7: With `resp_nocrc` set, `crc_ok` reads 1 whatever the received CRC7.
- R8: With `busy_wait` set, done is held back after the reply, or after the frame if no reply is expected, until DAT0 is sampled high on a rising card-clock edge.
- R9: If no start bit arrives within 64 rising card-clock edges after the line is released, done and `timed_out` go high on the 64th edge.
- R10: `done_irq` stays high until `done_clr` is pulsed, which also clears `timed_out`. A new command clears both when it starts.
- R11: `soft_rst` returns the engine to idle within one clock: the line is released and `done_irq` is cleared, and no completion follows.
- R12: `cmd_go` has no effect while a command is in progress.
- R13: With `resp_en` low, done rises on the falling edge that releases the line, and `crc_ok` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Abandon the command, return to idle |
| clk_div | input | DIV_W | Card clock divider N |
| cmd_go | input | 1 | Start strobe, one clock |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_en | input | 1 | A reply is expected |
| resp_len | input | LEN_W | Reply bits after start, end bit excluded, minus one |
| resp_nocrc | input | 1 | Reply carries no CRC7; treat as good |
| resp_long | input | 1 | Long reply: skip the 7 header bits in the CRC |
| busy_wait | input | 1 | Wait for DAT0 high before done |
| done_clr | input | 1 | Write-one clear of done and timeout |
| card_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line as seen at the pin |
| dat0_in | input | 1 | DAT0 line for busy sensing |
| resp_data | output | RESP_W | Captured reply bits |
| crc_ok | output | 1 | Reply CRC7 status |
| timed_out | output | 1 | No start bit arrived |
| done_irq | output | 1 | Sticky completion flag |

## Verification
The bench builds the engine with its defaults: a 4-bit divider, an 8-bit length field and a 136-bit capture register. This lets it sweep the divider from 0 to 3 and run both reply lengths at every setting. A card model in the bench computes frame and reply CRCs by polynomial long division. The timeout is checked at the exact edge (63 against 64). Corrupted CRCs, the skipped long header, busy holds, a start strobe during transmission and a soft reset in mid-frame are all reachable at these sizes.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RESP,
        ST_BUSY
    } eng_state_e;

    localparam int          FRAME_W   = 48;
    localparam int          HDR_W     = 40;
    localparam int          LONG_SKIP = 7;
    localparam logic [6:0]  CRC7_POLY = 7'h09;

    // one serial CRC7 step, MSB-first
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_hdr(input logic [HDR_W-1:0] m);
        logic [6:0] c;
        c = 7'h00;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            c = crc7_step(c, m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_cmd_clkgen.sv
module sd_cmd_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             card_clk,
    output logic             rise_ev,
    output logic             fall_ev
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } cg_t;

    cg_t  q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = (q.cnt >= div);
        if (tick) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign rise_ev  = tick & ~q.ph;
    assign fall_ev  = tick &  q.ph;
    assign card_clk = q.ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sd_cmd_txshift.sv
module sd_cmd_txshift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] frame_in,
    output logic         msb
);
    logic [W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = frame_in;
        else if (shift) sr_d = {sr_q[W-2:0], 1'b1};
    end

    assign msb = sr_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/sd_cmd_rxcrc.sv
module sd_cmd_rxcrc
    import sd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       bit_in,
    output logic [6:0] crc_nxt
);
    logic [6:0] crc_q, crc_d;

    always_comb begin
        crc_nxt = en ? crc7_step(crc_q, bit_in) : crc_q;
        crc_d   = clr ? 7'h00 : crc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 7'h00;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int LEN_W   = 8,
    parameter int RESP_W  = 136,
    parameter int TO_CLKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_go,
    input  logic [5:0]        cmd_index,
    input  logic [31:0]       cmd_arg,
    input  logic              resp_en,
    input  logic [LEN_W-1:0]  resp_len,
    input  logic              resp_nocrc,
    input  logic              resp_long,
    input  logic              busy_wait,
    input  logic              done_clr,
    output logic              card_clk,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in,
    input  logic              dat0_in,
    output logic [RESP_W-1:0] resp_data,
    output logic              crc_ok,
    output logic              timed_out,
    output logic              done_irq
);
    localparam int CNT_W = (LEN_W > 6) ? LEN_W : 6;
    localparam int TO_W  = (TO_CLKS > 2) ? $clog2(TO_CLKS) : 1;
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] SKIP_CNT  = CNT_W'(LONG_SKIP);
    localparam logic [TO_W-1:0]  TO_LAST   = TO_W'(TO_CLKS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  bcnt;
        logic [TO_W-1:0]   tcnt;
        logic              out;
        logic              oe;
        logic [RESP_W-1:0] resp;
        logic              ok;
        logic              tmo;
        logic              done;
        logic              f_resp;
        logic [CNT_W-1:0]  f_len;
        logic              f_nocrc;
        logic              f_long;
        logic              f_busy;
    } eng_t;

    eng_t q, d;

    logic               rise_ev, fall_ev;
    logic               tx_load, tx_shift, tx_msb;
    logic               crc_clr, crc_en;
    logic [6:0]         crc_nxt;
    logic [FRAME_W-1:0] frame;
    logic [HDR_W-1:0]   hdr;
    logic [CNT_W-1:0]   skip;

    sd_cmd_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (clk_div),
        .card_clk (card_clk),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    assign hdr   = {2'b01, cmd_index, cmd_arg};
    assign frame = {hdr, crc7_hdr(hdr), 1'b1};

    sd_cmd_txshift #(.W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .shift    (tx_shift),
        .frame_in (frame),
        .msb      (tx_msb)
    );

    sd_cmd_rxcrc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .en      (crc_en),
        .bit_in  (cmd_in),
        .crc_nxt (crc_nxt)
    );

    assign skip = q.f_long ? SKIP_CNT : '0;

    always_comb begin
        d        = q;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        if (soft_rst) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.out  = 1'b1;
            d.done = 1'b0;
            d.tmo  = 1'b0;
            d.ok   = 1'b0;
        end else begin
            if (done_clr) begin
                d.done = 1'b0;
                d.tmo  = 1'b0;
            end
            unique case (q.st)
                ST_IDLE: begin
                    if (cmd_go) begin
                        tx_load   = 1'b1;
                        crc_clr   = 1'b1;
                        d.st      = ST_SEND;
                        d.bcnt    = '0;
                        d.resp    = '0;
                        d.ok      = 1'b0;
                        d.tmo     = 1'b0;
                        d.done    = 1'b0;
                        d.f_resp  = resp_en;
                        d.f_len   = CNT_W'(resp_len);
                        d.f_nocrc = resp_nocrc;
                        d.f_long  = resp_long;
                        d.f_busy  = busy_wait;
                    end
                end
                ST_SEND: begin
                    if (fall_ev) begin
                        if (q.bcnt == FRAME_CNT) begin
                            d.oe   = 1'b0;
                            d.out  = 1'b1;
                            d.bcnt = '0;
                            d.tcnt = '0;
                            if (q.f_resp) begin
                                d.st = ST_WAIT;
                            end else if (q.f_busy) begin
                                d.st = ST_BUSY;
                                d.ok = 1'b1;
                            end else begin
                                d.st   = ST_IDLE;
                                d.ok   = 1'b1;
                                d.done = 1'b1;
                            end
                        end else begin
                            d.oe     = 1'b1;
                            d.out    = tx_msb;
                            tx_shift = 1'b1;
                            d.bcnt   = q.bcnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rise_ev) begin
                        if (!cmd_in) begin
                            d.st   = ST_RESP;
                            d.bcnt = '0;
                        end else if (q.tcnt == TO_LAST) begin
                            d.st   = ST_IDLE;
                            d.tmo  = 1'b1;
                            d.done = 1'b1;
                        end else begin
                            d.tcnt = q.tcnt + 1'b1;
                        end
                    end
                end
                ST_RESP: begin
                    if (rise_ev) begin
                        d.resp = {q.resp[RESP_W-2:0], cmd_in};
                        crc_en = (q.bcnt >= skip);
                        if (q.bcnt == q.f_len) begin
                            d.ok = q.f_nocrc || (crc_nxt == 7'h00);
                            if (q.f_busy) begin
                                d.st = ST_BUSY;
                            end else begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                            end
                        end else begin
                            d.bcnt = q.bcnt + 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (rise_ev && dat0_in) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.out <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cmd_out   = q.out;
    assign cmd_oe    = q.oe;
    assign resp_data = q.resp;
    assign crc_ok    = q.ok;
    assign timed_out = q.tmo;
    assign done_irq  = q.done;

endmodule

module sd_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic cmd_go,
    input logic done_clr,
    input logic card_clk,
    input logic cmd_out,
    input logic cmd_oe,
    input logic timed_out,
    input logic done_irq
);
    p_oe_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $fell(card_clk));

    p_out_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_out) |-> ($fell(card_clk) || $past(soft_rst)));

    p_done_released_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !cmd_oe);

    p_tmo_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done_irq);

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && done_clr && !cmd_go) |=> !done_irq);

    p_soft_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!cmd_oe && cmd_out && !done_irq));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cmd_go    (cmd_go),
    .done_clr  (done_clr),
    .card_clk  (card_clk),
    .cmd_out   (cmd_out),
    .cmd_oe    (cmd_oe),
    .timed_out (timed_out),
    .done_irq  (done_irq)
);

// File: tb/sd_cmd_engine_tb.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic [3:0]   clk_div = 4'd0;
    logic         cmd_go = 1'b0;
    logic [5:0]   cmd_index = '0;
    logic [31:0]  cmd_arg = '0;
    logic         resp_en = 1'b0;
    logic [7:0]   resp_len = '0;
    logic         resp_nocrc = 1'b0;
    logic         resp_long = 1'b0;
    logic         busy_wait = 1'b0;
    logic         done_clr = 1'b0;
    logic         card_clk, cmd_out, cmd_oe;
    logic         cmd_in = 1'b1;
    logic         dat0_in = 1'b1;
    logic [135:0] resp_data;
    logic         crc_ok, timed_out, done_irq;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sd_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_div(clk_div),
        .cmd_go(cmd_go), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .resp_en(resp_en), .resp_len(resp_len), .resp_nocrc(resp_nocrc),
        .resp_long(resp_long), .busy_wait(busy_wait), .done_clr(done_clr),
        .card_clk(card_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_in(cmd_in), .dat0_in(dat0_in), .resp_data(resp_data),
        .crc_ok(crc_ok), .timed_out(timed_out), .done_irq(done_irq)
    );

    task automatic chk(input logic ok, input string req, input logic [135:0] act, input logic [135:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // CRC7 by polynomial long division (x^7+x^3+1 -> 8'h89)
    function automatic logic [6:0] crc_div(input logic [127:0] m);
        logic [134:0] v;
        v = {m, 7'b0};
        for (int i = 134; i >= 7; i--) begin
            if (v[i]) v[i-:8] = v[i-:8] ^ 8'h89;
        end
        return v[6:0];
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] i, input logic [31:0] a);
        logic [39:0] h;
        h = {2'b01, i, a};
        return {h, crc_div({88'b0, h}), 1'b1};
    endfunction

    task automatic issue(input logic [5:0] i, input logic [31:0] a, input logic ren,
                         input logic [7:0] len, input logic nc, input logic lg, input logic bw);
        @(negedge clk);
        cmd_index = i; cmd_arg = a; resp_en = ren; resp_len = len;
        resp_nocrc = nc; resp_long = lg; busy_wait = bw; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic get_frame(output logic [47:0] f);
        int g = 0;
        while (!cmd_oe && g < 20000) begin @(negedge clk); g++; end
        f = '0;
        for (int k = 0; k < 48; k++) begin
            @(posedge card_clk); #1;
            f = {f[46:0], cmd_out};
        end
        @(negedge card_clk); #1;
        chk(!cmd_oe && cmd_out, "R2 line released after frame", {cmd_oe, cmd_out}, 2'b01);
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done_irq && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        #1;
        chk(!done_irq && !timed_out, "R10 write-one clear", {done_irq, timed_out}, 2'b00);
    endtask

    task automatic do_resp(input logic [5:0] i, input logic [31:0] a, input logic lg,
                           input logic bad, input logic nc, input int dly, input logic bw);
        logic [47:0]  f;
        logic [135:0] rb;
        logic [119:0] p;
        int           n;
        logic         exp_ok;
        if (!lg) begin
            rb = {90'b0, 1'b0, i, a, crc_div({88'b0, 2'b00, i, a})};
            n  = 46;
        end else begin
            p  = {a, ~a, a ^ 32'h5a5a_a5a5, a[23:0]};
            rb = {2'b0, 1'b0, 6'h3f, p, crc_div({8'b0, p})};
            n  = 134;
        end
        if (bad) rb[0] = ~rb[0];
        exp_ok = nc || !bad;
        if (bw) dat0_in = 1'b0;
        issue(i, a, 1'b1, lg ? 8'd133 : 8'd45, nc, lg, bw);
        get_frame(f);
        chk(f == exp_frame(i, a), "R1 frame bits", f, exp_frame(i, a));
        repeat (dly) @(negedge card_clk);
        #1 cmd_in = 1'b0;
        for (int k = n - 1; k >= 0; k--) begin
            @(negedge card_clk); #1;
            cmd_in = rb[k];
        end
        @(negedge card_clk); #1 cmd_in = 1'b1;
        if (bw) begin
            repeat (4) @(posedge card_clk); #1;
            chk(!done_irq, "R8 done held while DAT0 low", done_irq, 0);
            @(negedge card_clk); #1 dat0_in = 1'b1;
            @(posedge card_clk); #1;
            chk(done_irq, "R8 done after DAT0 high", done_irq, 1);
        end
        wait_done();
        chk(done_irq && !timed_out, "R4 reply completes", {done_irq, timed_out}, 2'b10);
        chk(resp_data == rb, lg ? "R6 long capture" : "R4 short capture", resp_data, rb);
        chk(crc_ok == exp_ok, nc ? "R7 nocrc status" : (lg ? "R6 long crc status" : "R5 short crc status"),
            crc_ok, exp_ok);
        clear_done();
    endtask

    initial begin
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [47:0] f;
        real t1, t2;
        repeat (4) @(negedge clk);
        chk(!cmd_oe && cmd_out && !done_irq && !timed_out, "R2 reset state",
            {cmd_oe, cmd_out, done_irq, timed_out}, 4'b0100);
        rst_n = 1'b1;

        for (int dv = 0; dv < 4; dv++) begin
            @(negedge clk) clk_div = 4'(dv);
            repeat (3) @(posedge card_clk);
            t1 = $realtime;
            @(posedge card_clk);
            t2 = $realtime;
            chk(int'((t2 - t1) / 5.0) == 2 * (dv + 1), "R3 card clock period",
                int'((t2 - t1) / 5.0), 2 * (dv + 1));
            for (int k = 0; k < 2; k++) begin
                do_resp(6'((dv * 13 + k * 7 + 2) % 64), 32'h1357_9bdf ^ (32'(dv) << (8 * k)) ^ 32'(k * 77),
                        1'b0, 1'b0, 1'b0, k, 1'b0);
            end
            do_resp(6'h02, 32'hc0de_0000 + 32'(dv), 1'b1, 1'b0, 1'b0, 0, 1'b0);
        end

        @(negedge clk) clk_div = 4'd1;
        do_resp(6'h0d, 32'hdead_beef, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        do_resp(6'h0d, 32'hdead_beef, 1'b0, 1'b1, 1'b1, 3, 1'b0);
        do_resp(6'h09, 32'h0102_0304, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        do_resp(6'h07, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 20, 1'b1);

        // R13 no reply
        issue(6'h00, 32'h0, 1'b0, 8'd45, 1'b0, 1'b0, 1'b0);
        get_frame(f);
        chk(f == exp_frame(6'h00, 32'h0), "R1 frame index 0", f, exp_frame(6'h00, 32'h0));
        chk(done_irq && crc_ok && !timed_out, "R13 done at release",
            {done_irq, crc_ok, timed_out}, 3'b110);
        clear_done();

        // R8 busy without reply
        dat0_in = 1'b0;
        issue(6'h0c, 32'h0, 1'b0, 8'd45, 1'b0, 1'b0, 1'b1);
        get_frame(f);
        repeat (10) @(posedge card_clk); #1;
        chk(!done_irq, "R8 no reply, DAT0 low", done_irq, 0);
        @(negedge card_clk); #1 dat0_in = 1'b1;
        @(posedge card_clk); #1;
        chk(done_irq, "R8 no reply, DAT0 released", done_irq, 1);
        clear_done();

        // R9 timeout exact edge
        issue(6'h08, 32'h0000_01aa, 1'b1, 8'd45, 1'b0, 1'b0, 1'b0);
        get_frame(f);
        repeat (63) @(posedge card_clk); #1;
        chk(!done_irq, "R9 not done at edge 63", done_irq, 0);
        @(posedge card_clk); #1;
        chk(done_irq && timed_out, "R9 timeout at edge 64", {done_irq, timed_out}, 2'b11);
        clear_done();

        // R12 start strobe during transmission
        issue(6'h11, 32'h2468_ace0, 1'b0, 8'd45, 1'b0, 1'b0, 1'b0);
        fork
            get_frame(f);
            begin
                repeat (5) @(negedge card_clk);
                @(negedge clk);
                cmd_index = 6'h3a; cmd_arg = 32'hffff_0000; cmd_go = 1'b1;
                @(negedge clk) cmd_go = 1'b0;
            end
        join
        chk(f == exp_frame(6'h11, 32'h2468_ace0), "R12 go ignored while busy", f,
            exp_frame(6'h11, 32'h2468_ace0));
        repeat (60) @(posedge card_clk); #1;
        chk(!cmd_oe, "R12 no second frame", cmd_oe, 0);
        clear_done();

        // R11 soft reset mid-frame
        issue(6'h12, 32'h5555_aaaa, 1'b1, 8'd45, 1'b0, 1'b0, 1'b0);
        while (!cmd_oe) @(negedge clk);
        repeat (10) @(negedge card_clk);
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        chk(!cmd_oe && cmd_out && !done_irq, "R11 soft reset releases line",
            {cmd_oe, cmd_out, done_irq}, 3'b010);
        repeat (80) @(posedge card_clk); #1;
        chk(!cmd_oe && !done_irq, "R11 idle after soft reset", {cmd_oe, done_irq}, 2'b00);
        do_resp(6'h12, 32'h5555_aaaa, 1'b0, 1'b0, 1'b0, 0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule